// File: doc/BRIEF.md
# Timer count-source and restart front end

This block sits in front of a 16-bit timer/counter. It decides in which cycles the counter advances, when it starts over, and when a capture event reaches it. A bus writes an 8-bit control word. From that word the block drives three outputs:

- a one-cycle count strobe, taken from a prescaler of the peripheral clock, from a tick supplied by a neighbouring timer, or from rising edges on an event line;
- a restart pulse that can follow the neighbouring timer's restart and overflow;
- a capture event that can be held back one cycle when two counters are chained into a 32-bit counter.

Control word layout:

| Bits | Field |
|---|---|
| 0 | enable |
| 3:1 | count source select |
| 4 | follow-restart |
| 5 | chain |
| 6 | standby-run flag, stored only |
| 7 | unused, always reads 0 |

The counter, the capture registers, interrupts and power modes sit outside the block. The standby-run flag is only stored, for a power controller to read.

Top module: `tmr_clk_front`

## Requirements
- R1: After reset the control word reads 0x00, and `cnt_en` and `cnt_restart` are low.
- R2: A write with `reg_we` high updates control bits 6:0 at the clock edge, and `reg_rdata` returns them from the next cycle. Bit 7 is never stored and always reads 0.
- R3: While bit 0 (enable) is 0, `cnt_en` and `cnt_restart` stay low whatever the other inputs do. The prescaler is held at zero, so after enable is set the dividers start from a fresh phase.
- R4: Select codes 0, 1, 2, 3 and 4 in bits 3:1 give one-cycle strobes every 1, 2, 8, 64 and 1024 cycles. Count the cycles after the edge that sets enable from 0; the first strobe falls in cycle d-1.
- R5: With select code 5, `cnt_en` follows `ext_tick` in the same cycle.
- R6: With select code 7, each rising edge on `evt_in` yields exactly one strobe. It falls in the cycle after the first clock edge that samples `evt_in` high.
- R7: Select code 6 never produces a strobe.
- R8: With bit 4 set and select code 0 to 4 or 7, `cnt_restart` is high in every cycle where `ext_restart` or `ext_ovf` is high.
- R9: With bit 4 set and select code 5, `cnt_restart` follows `ext_restart` only; `ext_ovf` alone gives no restart.
- R10: With bit 4 clear, `cnt_restart` stays low.
- R11: With bit 5 clear, `capt_out` equals `capt_in` in the same cycle.
- R12: With bit 5 set, `capt_out` equals the value `capt_in` had one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 8 | Control word write data |
| reg_rdata | output | 8 | Control word read data |
| ext_tick | input | 1 | Count tick from the neighbouring timer |
| ext_restart | input | 1 | Restart indication from the neighbouring timer |
| ext_ovf | input | 1 | Overflow indication from the neighbouring timer |
| evt_in | input | 1 | Event line counted on rising edges |
| capt_in | input | 1 | Capture event request |
| cnt_en | output | 1 | One-cycle count strobe to the counter |
| cnt_restart | output | 1 | Counter restart pulse |
| capt_out | output | 1 | Capture event to the counter |

## Verification
The assertions check on every cycle the rules that hold from one cycle to the next:
- outputs stay quiet while disabled;
- the reserved code stays silent;
- bit 7 always reads 0;
- the capture path is transparent without chaining and delayed by one cycle with it;
- restart follows the neighbouring timer, but with the tick source ignores overflow;
- an event edge yields no back-to-back strobes.

Only the bench scenarios can show the things that span many cycles. These are the divider periods and their phase after enable, strobes matching event edges one for one, and agreement with a cycle-accurate reference model across random stimulus.

// File: rtl/tmr_clk_front.sv
`timescale 1ns/1ps
module tmr_clk_front #(
  parameter int PRESC_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ext_tick,
  input  logic       ext_restart,
  input  logic       ext_ovf,
  input  logic       evt_in,
  input  logic       capt_in,
  output logic       cnt_en,
  output logic       cnt_restart,
  output logic       capt_out
);
  localparam logic [2:0] SEL_EXT = 3'd5;
  localparam logic [2:0] SEL_EVT = 3'd7;

  logic [6:0]         ctrl;
  logic [PRESC_W-1:0] presc;
  logic               evt_q, evt_q2, capt_q, tick;

  wire       en    = ctrl[0];
  wire [2:0] sel   = ctrl[3:1];
  wire       sync  = ctrl[4];
  wire       chain = ctrl[5];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctrl <= '0;
    else if (reg_we) ctrl <= reg_wdata[6:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   presc <= '0;
    else if (!en) presc <= '0;
    else          presc <= presc + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      evt_q  <= 1'b0;
      evt_q2 <= 1'b0;
      capt_q <= 1'b0;
    end else begin
      evt_q  <= evt_in;
      evt_q2 <= evt_q;
      capt_q <= capt_in;
    end

  always_comb begin
    case (sel)
      3'd0:    tick = 1'b1;
      3'd1:    tick = presc[0];
      3'd2:    tick = &presc[2:0];
      3'd3:    tick = &presc[5:0];
      3'd4:    tick = &presc[9:0];
      SEL_EXT: tick = ext_tick;
      SEL_EVT: tick = evt_q & ~evt_q2;
      default: tick = 1'b0;
    endcase
  end

  assign cnt_en      = en & tick;
  assign cnt_restart = en & sync & (ext_restart | (ext_ovf & (sel != SEL_EXT)));
  assign capt_out    = chain ? capt_q : capt_in;
  assign reg_rdata   = {1'b0, ctrl};
endmodule

// File: rtl/tmr_clk_front_chk.sv
`timescale 1ns/1ps
module tmr_clk_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       ext_tick,
  input logic       ext_restart,
  input logic       ext_ovf,
  input logic       evt_in,
  input logic       capt_in,
  input logic       cnt_en,
  input logic       cnt_restart,
  input logic       capt_out
);
  wire       en  = reg_rdata[0];
  wire [2:0] sel = reg_rdata[3:1];

  assert_bit7_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7] == 1'b0);
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!cnt_en && !cnt_restart));
  assert_evt_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && en && sel == 3'd7 && !reg_we) |=> !cnt_en);
  assert_reserved_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd6) |-> !cnt_en);
  assert_restart_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && reg_rdata[4] && ext_restart) |-> cnt_restart);
  assert_tick_src_no_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd5 && !ext_restart) |-> !cnt_restart);
  assert_no_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[4] |-> !cnt_restart);
  assert_capt_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[5] |-> (capt_out == capt_in));
  assert_capt_delay_R12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[5] |-> (capt_out == $past(capt_in)));
endmodule

bind tmr_clk_front tmr_clk_front_chk u_chk (.*);

// File: tb/tmr_clk_front_bench.sv
`timescale 1ns/1ps
module tmr_clk_front_bench;
  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic ext_tick = 0, ext_restart = 0, ext_ovf = 0, evt_in = 0, capt_in = 0;
  logic cnt_en, cnt_restart, capt_out;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  tmr_clk_front u_tmr_clk_front (.*);

  always #10 clk = ~clk;

  // behavioural reference state
  int m_ctrl = 0, m_cyc = 0;
  bit m_evt_cur = 0, m_evt_prev = 0, m_capt_prev = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cyc = 0; m_evt_cur = 0; m_evt_prev = 0; m_capt_prev = 0;
    end else begin
      m_cyc = (m_ctrl % 2 == 1) ? (m_cyc + 1) % 1024 : 0;
      m_evt_prev = m_evt_cur;
      m_evt_cur = evt_in;
      m_capt_prev = capt_in;
      if (reg_we) m_ctrl = reg_wdata % 128;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int div_of(input int s);
    case (s)
      0: return 1;  1: return 2;  2: return 8;  3: return 64;
      default: return 1024;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int s, e_en, e_rs;
      bit en, sy;
      string t;
      s  = (m_ctrl / 2) % 8;
      en = m_ctrl % 2;
      sy = (m_ctrl / 16) % 2;
      if (!en) begin e_en = 0; t = "R3"; end
      else if (s < 5) begin e_en = (m_cyc % div_of(s)) == div_of(s) - 1; t = "R4"; end
      else if (s == 5) begin e_en = ext_tick; t = "R5"; end
      else if (s == 6) begin e_en = 0; t = "R7"; end
      else begin e_en = m_evt_cur && !m_evt_prev; t = "R6"; end
      chk({t, " cnt_en"}, cnt_en, e_en);
      e_rs = en && sy && (ext_restart || (ext_ovf && s != 5));
      chk(!sy ? "R10 restart" : (s == 5 ? "R9 restart" : "R8 restart"), cnt_restart, e_rs);
      if ((m_ctrl / 32) % 2) chk("R12 capt", capt_out, m_capt_prev);
      else chk("R11 capt", capt_out, capt_in);
      chk("R2 rdata", reg_rdata, m_ctrl);
    end
  end

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1 reg_we = 1; reg_wdata = d;
    @(posedge clk); #1 reg_we = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #4_000_000;
    n_bad++; n_cmp++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset rdata", reg_rdata, 0);
    chk("R1 reset cnt_en", cnt_en, 0);
    chk("R1 reset restart", cnt_restart, 0);

    wr(8'hFF);
    @(negedge clk) chk("R2 bit7 dropped", reg_rdata, 8'h7F);
    wr(8'h00);

    // R4 divider periods and phase
    for (int s = 0; s < 5; s++) begin
      int cnt, first;
      wr(8'h00);
      wr(8'((s << 1) | 1));
      cnt = 0; first = -1;
      for (int i = 0; i < 2048; i++) begin
        @(negedge clk);
        if (cnt_en) begin cnt++; if (first < 0) first = i; end
      end
      chk("R4 strobe count", cnt, 2048 / div_of(s));
      chk("R4 first strobe", first, div_of(s) - 1);
    end

    // R3 disabled: sync set but enable clear
    wr(8'h10);
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1 ext_restart = i[0]; ext_ovf = 1; evt_in = i[1]; ext_tick = 1;
      @(negedge clk);
      chk("R3 disabled strobe", cnt_en, 0);
      chk("R3 disabled restart", cnt_restart, 0);
    end
    #1 ext_restart = 0; ext_ovf = 0; ext_tick = 0; evt_in = 0;

    // R5 external tick
    wr(8'h0B);
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #1 ext_tick = $urandom_range(0, 1);
    end
    @(posedge clk); #1 ext_tick = 1;
    @(negedge clk) chk("R5 tick pass", cnt_en, 1);
    @(posedge clk); #1 ext_tick = 0;

    // R6 event edges
    wr(8'h00);
    repeat (3) @(posedge clk);
    wr(8'h0F);
    begin
      int edges, strobes;
      bit prev;
      edges = 0; strobes = 0; prev = 0;
      for (int i = 0; i < 200; i++) begin
        bit v;
        v = $urandom_range(0, 1);
        @(posedge clk); #1 evt_in = v;
        if (v && !prev) edges++;
        prev = v;
        @(negedge clk) if (cnt_en) strobes++;
      end
      repeat (3) @(negedge clk) if (cnt_en) strobes++;
      chk("R6 strobes per edge", strobes, edges);
    end

    // R7 reserved code
    wr(8'h0D);
    begin
      int strobes;
      strobes = 0;
      for (int i = 0; i < 100; i++) begin
        @(posedge clk); #1 evt_in = $urandom_range(0, 1); ext_tick = $urandom_range(0, 1);
        @(negedge clk) if (cnt_en) strobes++;
      end
      chk("R7 reserved strobes", strobes, 0);
    end
    #1 evt_in = 0; ext_tick = 0;

    // R8 restart follows overflow and restart
    wr(8'h11);
    @(posedge clk); #1 ext_ovf = 1;
    @(negedge clk) chk("R8 ovf restart", cnt_restart, 1);
    @(posedge clk); #1 ext_ovf = 0; ext_restart = 1;
    @(negedge clk) chk("R8 ext restart", cnt_restart, 1);
    @(posedge clk); #1 ext_restart = 0;

    // R9 tick source ignores overflow
    wr(8'h1B);
    @(posedge clk); #1 ext_ovf = 1;
    @(negedge clk) chk("R9 ovf ignored", cnt_restart, 0);
    @(posedge clk); #1 ext_ovf = 0; ext_restart = 1;
    @(negedge clk) chk("R9 restart seen", cnt_restart, 1);
    @(posedge clk); #1 ext_restart = 0;

    // R10 sync off
    wr(8'h01);
    @(posedge clk); #1 ext_ovf = 1; ext_restart = 1;
    @(negedge clk) chk("R10 no restart", cnt_restart, 0);
    @(posedge clk); #1 ext_ovf = 0; ext_restart = 0;

    // R11 / R12 capture path
    @(posedge clk); #1 capt_in = 1;
    @(negedge clk) chk("R11 capt same cycle", capt_out, 1);
    @(posedge clk); #1 capt_in = 0;
    wr(8'h21);
    @(posedge clk); #1 capt_in = 1;
    @(negedge clk) chk("R12 capt not yet", capt_out, 0);
    @(posedge clk); #1 capt_in = 0;
    @(negedge clk) chk("R12 capt delayed", capt_out, 1);

    // random mix compared by the model
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1
      capt_in = $urandom_range(0, 1); ext_ovf = $urandom_range(0, 1);
      ext_restart = $urandom_range(0, 1); ext_tick = $urandom_range(0, 1);
      evt_in = $urandom_range(0, 1);
      if (i % 50 == 0) begin reg_we = 1; reg_wdata = 8'($urandom); end
      else reg_we = 0;
    end
    #1 reg_we = 0;
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule